// File: doc/BRIEF.md
# Segment Selector Address Translator

This block converts a segmented logical address into a flat linear address. A request carries a 16-bit selector and a 32-bit offset. One bit of the selector chooses one of two descriptor tables. The remaining index bits locate an 8-byte descriptor inside that table. The block reads the descriptor as two 32-bit words through a synchronous memory read port. It then assembles the 32-bit segment base from the descriptor and returns base plus offset.

The base addresses of the two tables are held in two registers. A plain register-write port loads them. The block works on one translation at a time. A descriptor whose present flag is clear returns a not-present indication instead of an address. Limit checks, privilege checks and descriptor caching are not part of this block.

Both stream interfaces use valid/ready. An input request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the result has been taken. A result is taken on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result is held unchanged. The memory port has no back-pressure: data for a request issued in one cycle appears on `mem_rdata` in the next cycle.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is held and right after it is released, `in_ready` is 1, `out_valid` is 0 and `mem_req` is 0.
- R2: The descriptor address is the selector index (selector bits 15:3) times 8, plus a table base. Selector bit 2 picks the table base: 0 picks the global table base and 1 picks the local table base. The low descriptor word is requested at the descriptor address in the first cycle after acceptance. The high word is requested at that address plus 4 in the next cycle.
- R3: The segment base is assembled from the 64-bit descriptor, where the low word is bits 31:0 and the high word is bits 63:32. Base bits 15:0 come from descriptor bits 31:16. Base bits 23:16 come from descriptor bits 39:32. Base bits 31:24 come from descriptor bits 63:56. `out_lin` is base plus offset modulo 2^32, and this holds up to the largest index, 8191.
- R4: A descriptor whose assembled base is zero yields `out_lin` equal to the offset.
- R5: Descriptor bit 47 (bit 15 of the high word) is the present flag. When this bit is 0, the result has `out_np` = 1 and `out_lin` = 0. When it is 1, the result has `out_np` = 0.
- R6: Selector bits 1:0 have no effect on the result or on the memory addresses.
- R7: Only one translation is in flight. `in_ready` is 0 from the accepting edge until the edge where the result is taken. It is also 0 whenever `out_valid` is 1.
- R8: `out_valid` rises after the third rising edge that follows the accepting edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_lin` and `out_np` hold their values.
- R10: When `cfg_we` is 1 at a rising edge, `cfg_data` loads the table base chosen by `cfg_tbl` (0 = global, 1 = local). A translation uses the table bases as they stood at its accepting edge. A write during a translation therefore affects only later translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table base write strobe |
| cfg_tbl | input | 1 | Table base to write: 0 global, 1 local |
| cfg_data | input | 32 | Table base write value |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_sel | input | 16 | Selector: index 15:3, table bit 2, privilege 1:0 |
| in_off | input | 32 | Offset within the segment |
| mem_req | output | 1 | Descriptor memory read request |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_lin | output | 32 | Linear address (0 when not present) |
| out_np | output | 1 | Descriptor not present |

## Verification
A wrong sequencer state shows at the ports within one cycle. It appears as a missing or extra `mem_req`, a read address other than the expected base-plus-index word, or an `out_valid` or `in_ready` level that is off by a cycle. A wrongly captured descriptor word or table base stays hidden until the result. It then shows as a wrong `out_lin` or `out_np` three cycles after acceptance. The bench therefore compares `in_ready`, `out_valid`, `mem_req` and `mem_addr` against a behavioural model on every clock. It compares the result value whenever `out_valid` is high, including every cycle of a stall.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 16;
  localparam int IDX_LSB    = 3;
  localparam int IDX_W      = SEL_W - IDX_LSB;
  localparam int TBL_BIT    = 2;
  localparam int DESC_SHIFT = 3;   // 8-byte descriptors
  localparam int WORD_BYTES = 4;
  localparam int N_TBL      = 2;
  localparam int LATENCY    = 3;   // edges from accept to result

  typedef enum logic [1:0] {
    FT_IDLE,
    FT_LO,
    FT_HI,
    FT_FIN
  } fetch_st_e;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } seg_desc_t;

  // base is scattered over three descriptor fields
  function automatic logic [31:0] desc_base(input seg_desc_t d);
    return {d.hi[31:24], d.hi[7:0], d.lo[31:16]};
  endfunction

  function automatic logic desc_present(input seg_desc_t d);
    return d.hi[15];
  endfunction
endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs
  import seg_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NTBL = N_TBL,
  localparam int TW  = (NTBL > 1) ? $clog2(NTBL) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [TW-1:0]            wr_tbl,
  input  logic [AW-1:0]            wr_data,
  output logic [NTBL-1:0][AW-1:0]  base_o
);
  for (genvar g = 0; g < NTBL; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g] <= '0;
      end else if (wr_en && (wr_tbl == TW'(g))) begin
        base_o[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output seg_desc_t     desc
);
  fetch_st_e     st_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FT_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        FT_IDLE: if (start) begin
          st_q   <= FT_LO;
          addr_q <= start_addr;
        end
        FT_LO: begin
          st_q   <= FT_HI;
          addr_q <= addr_q + AW'(WORD_BYTES);
        end
        FT_HI: begin
          st_q <= FT_FIN;
          lo_q <= mem_rdata;   // low word returned for the FT_LO request
        end
        FT_FIN: st_q <= FT_IDLE;
        default: st_q <= FT_IDLE;
      endcase
    end
  end

  assign mem_req  = (st_q == FT_LO) || (st_q == FT_HI);
  assign mem_addr = addr_q;
  assign done     = (st_q == FT_FIN);
  assign desc     = '{hi: mem_rdata, lo: lo_q};

  // R2
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FT_LO) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));

  // R2
  one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FT_HI) |=> !mem_req);
endmodule

// File: rtl/seg_result.sv
module seg_result
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  seg_desc_t     desc,
  input  logic [AW-1:0] offset,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_lin,
  output logic          out_np
);
  logic          present;
  logic [AW-1:0] sum;

  assign present = desc_present(desc);
  assign sum     = AW'(desc_base(desc)) + offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lin   <= '0;
      out_np    <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_np    <= !present;
      out_lin   <= present ? sum : '0;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lin) && $stable(out_np)));

  // R8
  load_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_tbl,
  input  logic [AW-1:0]    cfg_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SEL_W-1:0] in_sel,
  input  logic [AW-1:0]    in_off,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_lin,
  output logic             out_np
);
  logic [N_TBL-1:0][AW-1:0] tbl_base;
  logic                     busy_q;
  logic                     accept;
  logic [AW-1:0]            off_q;
  logic [AW-1:0]            desc_addr;
  logic [IDX_W-1:0]         idx;
  logic                     fetch_done;
  seg_desc_t                fetch_desc;

  seg_tbl_regs #(.AW(AW), .NTBL(N_TBL)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_tbl  (cfg_tbl),
    .wr_data (cfg_data),
    .base_o  (tbl_base)
  );

  assign in_ready  = !busy_q;
  assign accept    = in_valid && in_ready;
  assign idx       = in_sel[SEL_W-1:IDX_LSB];
  assign desc_addr = tbl_base[in_sel[TBL_BIT]] + AW'({idx, {DESC_SHIFT{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      off_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      off_q  <= in_off;
    end else if (out_valid && out_ready) begin
      busy_q <= 1'b0;
    end
  end

  seg_fetch #(.AW(AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (desc_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .done       (fetch_done),
    .desc       (fetch_desc)
  );

  seg_result #(.AW(AW)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fetch_done),
    .desc      (fetch_desc),
    .offset    (off_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_lin   (out_lin),
    .out_np    (out_np)
  );

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7
  no_accept_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_tbl = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sel = '0;
  logic [31:0] in_off = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_lin;
  logic        out_np;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_sel(in_sel), .in_off(in_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_lin(out_lin), .out_np(out_np)
  );

  // descriptor memory image
  logic [31:0] mem_img [logic [31:0]];

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h5A00_0000 ^ a;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= rd_word(mem_addr);

  task automatic put_desc(input logic [31:0] a, input logic [31:0] base, input logic pres);
    mem_img[a]     = {base[15:0], 16'hFFFF};
    mem_img[a + 4] = {base[31:24], 8'h4F, pres, 7'h1A, base[23:16]};
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base [2];
  bit          m_busy;
  int          m_cnt;
  logic [31:0] m_addr, m_lin;
  logic        m_np;
  bit          model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base[0] = 0; m_base[1] = 0; m_busy = 0; m_cnt = 0;
    end else begin
      bit pre;
      pre = m_busy;
      if (m_busy) begin
        if (m_cnt >= 3 && out_ready) m_busy = 0;
        else if (m_cnt < 3) m_cnt++;
      end
      if (!pre && in_valid) begin
        logic [31:0] lo, hi, b;
        m_addr = m_base[in_sel[2]] + 32'(in_sel[15:3]) * 8;
        lo = rd_word(m_addr);
        hi = rd_word(m_addr + 4);
        b  = {hi[31:24], hi[7:0], lo[31:16]};
        m_np  = !hi[15];
        m_lin = m_np ? 32'h0 : b + in_off;
        m_busy = 1; m_cnt = 0;
      end
      if (cfg_we) m_base[cfg_tbl] = cfg_data;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      bit ev, er;
      ev = m_busy && m_cnt >= 3;
      er = m_busy && m_cnt < 2;
      chk(in_ready == !m_busy, "R7 in_ready", 32'(in_ready), 32'(!m_busy));
      chk(out_valid == ev, "R8 out_valid timing", 32'(out_valid), 32'(ev));
      chk(mem_req == er, "R2 mem_req", 32'(mem_req), 32'(er));
      if (er && mem_req)
        chk(mem_addr == m_addr + 32'(4 * m_cnt), "R2 mem_addr", mem_addr, m_addr + 32'(4 * m_cnt));
      if (ev && out_valid) begin
        chk(out_lin == m_lin, "R3 out_lin vs model", out_lin, m_lin);
        chk(out_np == m_np, "R5 out_np vs model", 32'(out_np), 32'(m_np));
      end
    end
  end

  function automatic logic [15:0] mk_sel(input int idx, input bit tbl, input logic [1:0] rpl);
    return {13'(idx), tbl, rpl};
  endfunction

  task automatic issue(input logic [15:0] s, input logic [31:0] o);
    in_valid = 1; in_sel = s; in_off = o;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic finish_one(input string req, input logic [31:0] exp_lin, input logic exp_np);
    while (!out_valid) @(negedge clk);
    chk(out_lin == exp_lin, req, out_lin, exp_lin);
    chk(out_np == exp_np, req, 32'(out_np), 32'(exp_np));
    while (!(out_valid && out_ready)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_base(input bit t, input logic [31:0] v);
    cfg_we = 1; cfg_tbl = t; cfg_data = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    put_desc(32'h1000 + 8,      32'h1234_5678, 1);
    put_desc(32'h1000 + 40,     32'h0000_0000, 1);
    put_desc(32'h1000 + 16,     32'hCAFE_0000, 0);
    put_desc(32'h8000 + 8,      32'hAABB_CCDD, 1);
    put_desc(32'h1000 + 65528,  32'hFFFF_FFF0, 1);
    put_desc(32'h2000 + 8,      32'h0BAD_0000, 1);

    @(negedge clk);
    // R1: reset values while reset is held
    chk(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    @(negedge clk); rst_n = 1; model_on = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && mem_req == 0, "R1 after release", 32'({in_ready, out_valid, mem_req}), 32'b100);

    wr_base(0, 32'h1000);
    wr_base(1, 32'h8000);

    // R3: base assembly plus offset
    issue(mk_sel(1, 0, 0), 32'h0000_0100);
    finish_one("R3 base+offset", 32'h1234_5778, 0);
    // R6: privilege bits have no effect
    issue(mk_sel(1, 0, 3), 32'h0000_0100);
    finish_one("R6 privilege ignored", 32'h1234_5778, 0);
    // R4: zero base
    issue(mk_sel(5, 0, 1), 32'hDEAD_BEEF);
    finish_one("R4 zero base", 32'hDEAD_BEEF, 0);
    // R2: table bit selects local table
    issue(mk_sel(1, 1, 0), 32'h0000_0003);
    finish_one("R2 local table", 32'hAABB_CCE0, 0);
    // R5: not present
    issue(mk_sel(2, 0, 0), 32'h0000_0010);
    finish_one("R5 not present", 32'h0, 1);
    // R3: largest index, sum wraps
    issue(mk_sel(8191, 0, 0), 32'h0000_0020);
    finish_one("R3 max index wrap", 32'h0000_0010, 0);

    // R9: stall on the output
    out_ready = 0;
    issue(mk_sel(1, 1, 2), 32'h0000_0100);
    while (!out_valid) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(out_valid && out_lin == 32'hAABB_CDDD, "R9 held under stall", out_lin, 32'hAABB_CDDD);
    end
    out_ready = 1;
    finish_one("R9 after release", 32'hAABB_CDDD, 0);

    // R10: write during a translation applies to the next one only
    issue(mk_sel(1, 0, 0), 32'h0000_0001);
    wr_base(0, 32'h2000);
    finish_one("R10 old base in flight", 32'h1234_5679, 0);
    issue(mk_sel(1, 0, 0), 32'h0000_0001);
    finish_one("R10 new base next", 32'h0BAD_0001, 0);

    // R7: back-to-back requests with valid held high
    in_valid = 1; in_sel = mk_sel(5, 0, 0); in_off = 32'h77;
    wr_base(0, 32'h1000);
    repeat (12) @(negedge clk);
    in_valid = 0;
    repeat (6) @(negedge clk);
    chk(in_ready == 1, "R7 idle after burst", 32'(in_ready), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule